// File: doc/BRIEF.md
# Flash Write Protection and Reset Gate

This block sits between a flash command decoder and the program/erase engine. It watches the memory control strobes (chip enable, output enable, write enable), the write-protect pin, the supply-good flag and the hardware reset pin, all active-low where they are pins. It decides whether a decoded program or erase request may reach the array. A write strobe counts only if it stays active for a minimum number of clock cycles. The decision is taken when that strobe closes, and a one-cycle `wr_permit` pulse grants it. Requests that target the boot region are refused while protection is asserted.

The block also qualifies the reset pin. A low pulse that is long enough raises a one-cycle abort request to the operation engine. Reads are then held off through `rd_ready` while the pin stays low and for a fixed recovery window after the pin is released. An aborted operation is never restarted by this block. The host has to issue it again. The boot region sits either at the top or at the bottom of the address space, chosen by a parameter.

Top module: `flash_write_guard`

## Requirements
- R1: A write strobe is active only while `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe whose closing cycle has `oe_n`=0, or any stretch where `oe_n`=0 or `ce_n`=1, produces no `wr_permit`.
- R2: While `pwr_good`=0 the strobe counter does not advance. If `pwr_good`=0 in the closing cycle, the strobe yields no `wr_permit`.
- R3: A strobe counts only after at least `GLITCH_CYC` consecutive active clock samples. It closes in the first cycle where `we_n`=1 or `ce_n`=1 while `oe_n`=1. A qualified close raises `wr_permit` for exactly the next cycle. With `GLITCH_CYC`−1 samples there is no pulse.
- R4: `wr_permit` requires `req`=1 in the strobe's last active cycle. The address is taken from that same cycle.
- R5: The protected span is `PROT_BLKS`×`BLK_WORDS` words. It sits at the top of the `2^ADDR_W` space when `PROT_TOP`=1 (1FE000h–1FFFFFh by default) and at the bottom when `PROT_TOP`=0 (000000h–001FFFh by default). A request inside the span is refused when `wp_n`=0 in the closing cycle. Requests outside the span are always allowed.
- R6: When `wp_driven`=0, `wp_n` is treated as 1, so the boot span is unprotected.
- R7: When `rst_pin_n` has been sampled 0 on `RST_MIN_CYC` consecutive edges, `op_abort` is 1 for exactly one cycle, right after the last of those edges. A low pulse of `RST_MIN_CYC`−1 samples raises no abort and leaves `rd_ready` at 1.
- R8: After an abort, `rd_ready` stays 0 while the pin is low. It also stays 0 for exactly `RECOV_CYC` cycles after the first edge that samples the pin high, and then returns to 1. No `wr_permit` appears during that time unless a new strobe is made.
- R9: A strobe whose closing cycle has `rst_pin_n`=0 or `rd_ready`=0 produces no `wr_permit`.
- R10: After synchronous `rst`, `wr_permit`=0, `op_abort`=0 and `rd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| wp_driven | input | 1 | 1 when the write-protect pin has a driver |
| pwr_good | input | 1 | Supply above write threshold |
| rst_pin_n | input | 1 | Hardware reset pin, active low, already synchronised |
| req | input | 1 | Decoded program/erase request |
| addr | input | ADDR_W | Target word address |
| wr_permit | output | 1 | One-cycle grant of the request |
| op_abort | output | 1 | One-cycle abort to the operation engine |
| rd_ready | output | 1 | Reads allowed |

## Verification
The assertions assume that every input is already synchronous to `clk`: pad synchronisers and analog detection sit upstream. They also assume that `req` and `addr` are valid whenever the strobe is active. The bench drives every input on the falling clock edge, holds it for whole cycles, and samples outputs on the falling edge. Every strobe therefore has an integer number of active samples, and there is exactly one closing cycle.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    typedef enum logic [1:0] {
        RS_READY   = 2'd0,
        RS_HELD    = 2'd1,
        RS_RECOVER = 2'd2
    } rst_phase_e;

    function automatic logic strobe_on(strobe_t s);
        return !s.ce_n && !s.we_n && s.oe_n;
    endfunction

    function automatic logic strobe_closing(strobe_t s);
        return s.oe_n && (s.we_n || s.ce_n);
    endfunction

endpackage

// File: rtl/fwg_strobe_qual.sv
module fwg_strobe_qual
    import fwg_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           ctl,
    input  logic              pwr_good,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              close_evt,
    output logic              req_q,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic [CW-1:0] width_cnt;
    logic          active;
    logic          qualified;

    assign active    = strobe_on(ctl) && pwr_good;
    assign qualified = width_cnt >= CW'(GLITCH_CYC);
    assign close_evt = qualified && pwr_good && strobe_closing(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            width_cnt <= '0;
            req_q     <= 1'b0;
            addr_q    <= '0;
        end else if (active) begin
            if (!qualified) begin
                width_cnt <= width_cnt + CW'(1);
            end
            req_q  <= req;
            addr_q <= addr;
        end else begin
            width_cnt <= '0;
        end
    end

endmodule

// File: rtl/fwg_region_chk.sv
module fwg_region_chk #(
    parameter int ADDR_W    = 21,
    parameter int BLK_WORDS = 4096,
    parameter int PROT_BLKS = 2,
    parameter bit PROT_TOP  = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_region
);
    localparam longint SPAN  = longint'(BLK_WORDS) * longint'(PROT_BLKS);
    localparam longint SPACE = longint'(1) << ADDR_W;

    generate
        if (PROT_TOP) begin : g_top
            localparam logic [ADDR_W-1:0] LOW_EDGE = ADDR_W'(SPACE - SPAN);
            assign in_region = addr >= LOW_EDGE;
        end else begin : g_bottom
            localparam logic [ADDR_W-1:0] HIGH_EDGE = ADDR_W'(SPAN);
            assign in_region = addr < HIGH_EDGE;
        end
    endgenerate

endmodule

// File: rtl/fwg_reset_seq.sv
module fwg_reset_seq
    import fwg_pkg::*;
#(
    parameter int RST_MIN_CYC = 4,
    parameter int RECOV_CYC   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic abort,
    output logic ready
);
    localparam int LW = $clog2(RST_MIN_CYC + 1);
    localparam int RW = $clog2(RECOV_CYC + 1);

    rst_phase_e    phase;
    logic [LW-1:0] low_cnt;
    logic [RW-1:0] rec_cnt;
    logic          long_low;

    assign long_low = !pin_n && (low_cnt == LW'(RST_MIN_CYC - 1));
    assign ready    = (phase == RS_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= RS_READY;
            low_cnt <= '0;
            rec_cnt <= '0;
            abort   <= 1'b0;
        end else begin
            abort <= 1'b0;
            if (pin_n) begin
                low_cnt <= '0;
            end else if (low_cnt != LW'(RST_MIN_CYC)) begin
                low_cnt <= low_cnt + LW'(1);
            end
            unique case (phase)
                RS_HELD: begin
                    if (pin_n) begin
                        phase   <= RS_RECOVER;
                        rec_cnt <= RW'(RECOV_CYC);
                    end
                end
                RS_RECOVER: begin
                    if (long_low) begin
                        phase <= RS_HELD;
                        abort <= 1'b1;
                    end else begin
                        rec_cnt <= rec_cnt - RW'(1);
                        if (rec_cnt == RW'(1)) begin
                            phase <= RS_READY;
                        end
                    end
                end
                default: begin
                    if (long_low) begin
                        phase <= RS_HELD;
                        abort <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard
    import fwg_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int BLK_WORDS   = 4096,
    parameter int PROT_BLKS   = 2,
    parameter bit PROT_TOP    = 1'b1,
    parameter int GLITCH_CYC  = 3,
    parameter int RST_MIN_CYC = 4,
    parameter int RECOV_CYC   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp_n,
    input  logic              wp_driven,
    input  logic              pwr_good,
    input  logic              rst_pin_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_permit,
    output logic              op_abort,
    output logic              rd_ready
);
    strobe_t           ctl;
    logic              close_evt;
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic              in_region;
    logic              wp_eff;
    logic              locked;
    logic              grant_d;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    fwg_strobe_qual #(
        .ADDR_W     (ADDR_W),
        .GLITCH_CYC (GLITCH_CYC)
    ) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .pwr_good  (pwr_good),
        .req       (req),
        .addr      (addr),
        .close_evt (close_evt),
        .req_q     (req_q),
        .addr_q    (addr_q)
    );

    fwg_region_chk #(
        .ADDR_W    (ADDR_W),
        .BLK_WORDS (BLK_WORDS),
        .PROT_BLKS (PROT_BLKS),
        .PROT_TOP  (PROT_TOP)
    ) u_region (
        .addr      (addr_q),
        .in_region (in_region)
    );

    fwg_reset_seq #(
        .RST_MIN_CYC (RST_MIN_CYC),
        .RECOV_CYC   (RECOV_CYC)
    ) u_rstseq (
        .clk   (clk),
        .rst   (rst),
        .pin_n (rst_pin_n),
        .abort (op_abort),
        .ready (rd_ready)
    );

    assign wp_eff  = wp_n || !wp_driven;
    assign locked  = in_region && !wp_eff;
    assign grant_d = close_evt && req_q && rst_pin_n && rd_ready && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_permit <= 1'b0;
        end else begin
            wr_permit <= grant_d;
        end
    end

endmodule

// File: rtl/fwg_checker.sv
module fwg_checker (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic pwr_good,
    input logic rst_pin_n,
    input logic wr_permit,
    input logic op_abort,
    input logic rd_ready
);
    AST_GRANT_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> $past(oe_n)); // R1
    AST_GRANT_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> $past(pwr_good)); // R2
    AST_GRANT_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> $past(we_n || ce_n)); // R3
    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> $past(rd_ready && rst_pin_n)); // R9
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        op_abort |=> !op_abort); // R7
    AST_ABORT_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
        op_abort |-> $past(!rst_pin_n)); // R7
    AST_ABORT_BLOCKS_READ: assert property (@(posedge clk) disable iff (rst)
        op_abort |-> !rd_ready); // R8
    AST_READY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_ready) |-> $past(rst_pin_n)); // R8
endmodule

bind flash_write_guard fwg_checker u_fwg_checker (.*);

// File: tb/flash_write_guard_bench.sv
module flash_write_guard_bench;
    localparam int AW  = 8;
    localparam int BW  = 16;
    localparam int NB  = 2;
    localparam int G   = 3;
    localparam int M   = 4;
    localparam int RC  = 6;
    localparam int SPN = BW * NB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic wp_n = 1'b1, wp_driven = 1'b1, pwr_good = 1'b1;
    logic rst_pin_n = 1'b1, req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic perm_t, abort_t, rdy_t, perm_b, abort_b, rdy_b;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_write_guard #(.ADDR_W(AW), .BLK_WORDS(BW), .PROT_BLKS(NB), .PROT_TOP(1'b1),
        .GLITCH_CYC(G), .RST_MIN_CYC(M), .RECOV_CYC(RC)) u_flash_write_guard (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wp_n(wp_n),
        .wp_driven(wp_driven), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n), .req(req),
        .addr(addr), .wr_permit(perm_t), .op_abort(abort_t), .rd_ready(rdy_t));

    flash_write_guard #(.ADDR_W(AW), .BLK_WORDS(BW), .PROT_BLKS(NB), .PROT_TOP(1'b0),
        .GLITCH_CYC(G), .RST_MIN_CYC(M), .RECOV_CYC(RC)) u_flash_write_guard_bot (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wp_n(wp_n),
        .wp_driven(wp_driven), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n), .req(req),
        .addr(addr), .wr_permit(perm_b), .op_abort(abort_b), .rd_ready(rdy_b));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // start_oe=0 keeps OE low during the strobe.
    // close: 0 WE rises, 1 CE rises, 2 OE drops, 3 supply drops.
    task automatic strobe(input int a, input bit rq, input int n, input bit start_oe,
                          input int close, output bit pt, output bit pb, output bit early);
        early = 1'b0;
        @(negedge clk);
        addr = AW'(a); req = rq; ce_n = 1'b0; we_n = 1'b0; oe_n = start_oe;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (perm_t || perm_b) early = 1'b1;
        end
        case (close)
            0: we_n = 1'b1;
            1: ce_n = 1'b1;
            2: oe_n = 1'b0;
            default: pwr_good = 1'b0;
        endcase
        @(negedge clk);
        pt = perm_t; pb = perm_b;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; req = 1'b0;
        @(negedge clk);
        if (perm_t || perm_b) early = 1'b1;
    endtask

    function automatic bit in_top(int a);
        return a >= (1 << AW) - SPN;
    endfunction

    function automatic bit in_bot(int a);
        return a < SPN;
    endfunction

    initial begin
        bit pt, pb, early, exp_t, exp_b, wpe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: state after synchronous reset
        chk(perm_t == 0 && perm_b == 0, "R10 permit idle", perm_t + perm_b, 0);
        chk(abort_t == 0 && abort_b == 0, "R10 abort idle", abort_t + abort_b, 0);
        chk(rdy_t == 1 && rdy_b == 1, "R10 ready", rdy_t + rdy_b, 2);

        // R5 / R6: full address sweep under every protect setting
        for (int a = 0; a < (1 << AW); a++) begin
            for (int mode = 0; mode < 3; mode++) begin
                wp_n = (mode == 1); wp_driven = (mode != 2);
                wpe = (mode != 0);
                strobe(a, 1'b1, G, 1'b1, 0, pt, pb, early);
                exp_t = !(in_top(a) && !wpe);
                exp_b = !(in_bot(a) && !wpe);
                chk(pt == exp_t, (mode == 2) ? "R6 top undriven" : "R5 top region", pt, exp_t);
                chk(pb == exp_b, (mode == 2) ? "R6 bottom undriven" : "R5 bottom region", pb, exp_b);
                chk(!early, "R3 single pulse", early, 0);
            end
        end
        wp_n = 1'b1; wp_driven = 1'b1;

        // R3: strobe width and both closing strobes
        for (int n = 1; n <= G + 2; n++) begin
            for (int c = 0; c < 2; c++) begin
                strobe(100, 1'b1, n, 1'b1, c, pt, pb, early);
                exp_t = (n >= G);
                chk(pt == exp_t && pb == exp_t, "R3 strobe width", pt, exp_t);
                chk(!early, "R3 no early pulse", early, 0);
            end
        end

        // R4: no request, no grant
        strobe(100, 1'b0, G, 1'b1, 0, pt, pb, early);
        chk(pt == 0 && pb == 0, "R4 request absent", pt, 0);

        // R1: OE low throughout, OE drop at close, CE high throughout
        strobe(100, 1'b1, G + 1, 1'b0, 0, pt, pb, early);
        chk(pt == 0 && pb == 0, "R1 OE low strobe", pt, 0);
        strobe(100, 1'b1, G + 1, 1'b1, 2, pt, pb, early);
        chk(pt == 0 && pb == 0, "R1 OE drop close", pt, 0);
        @(negedge clk);
        addr = 8'd100; req = 1'b1; ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1;
        repeat (G + 1) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        chk(perm_t == 0 && perm_b == 0, "R1 CE high", perm_t, 0);
        req = 1'b0;

        // R2: supply low throughout, supply lost at close
        pwr_good = 1'b0;
        strobe(100, 1'b1, G + 1, 1'b1, 0, pt, pb, early);
        chk(pt == 0 && pb == 0, "R2 supply low", pt, 0);
        pwr_good = 1'b1;
        strobe(100, 1'b1, G + 1, 1'b1, 3, pt, pb, early);
        chk(pt == 0 && pb == 0, "R2 supply lost at close", pt, 0);
        pwr_good = 1'b1;
        strobe(100, 1'b1, G, 1'b1, 0, pt, pb, early);
        chk(pt == 1 && pb == 1, "R2 supply restored", pt, 1);

        // R7: pulse one sample short of the minimum
        @(negedge clk);
        rst_pin_n = 1'b0;
        for (int i = 1; i <= M - 1; i++) begin
            @(negedge clk);
            chk(abort_t == 0 && abort_b == 0, "R7 short pulse abort", abort_t, 0);
            chk(rdy_t == 1 && rdy_b == 1, "R7 short pulse ready", rdy_t, 1);
        end
        rst_pin_n = 1'b1;
        @(negedge clk);
        chk(rdy_t == 1 && rdy_b == 1, "R7 ready after short pulse", rdy_t, 1);

        // R7 / R8: pulse longer than the minimum, then recovery window
        rst_pin_n = 1'b0;
        for (int i = 1; i <= M + 2; i++) begin
            @(negedge clk);
            chk(abort_t == (i == M) && abort_b == (i == M), "R7 abort timing", abort_t, (i == M));
            chk(rdy_t == (i < M), "R8 ready while held", rdy_t, (i < M));
        end
        rst_pin_n = 1'b1;
        for (int k = 1; k <= RC + 2; k++) begin
            @(negedge clk);
            chk(rdy_t == (k > RC) && rdy_b == (k > RC), "R8 recovery window", rdy_t, (k > RC));
            chk(perm_t == 0 && abort_t == 0, "R8 nothing resumed", perm_t + abort_t, 0);
        end

        // R9: closing cycle inside recovery
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (M) @(negedge clk);
        rst_pin_n = 1'b1;
        strobe(100, 1'b1, G, 1'b1, 0, pt, pb, early);
        chk(pt == 0 && pb == 0, "R9 during recovery", pt, 0);
        repeat (RC + 2) @(negedge clk);
        strobe(100, 1'b1, G, 1'b1, 0, pt, pb, early);
        chk(pt == 1 && pb == 1, "R9 after recovery", pt, 1);

        // R9: closing cycle with the pin low (short pulse)
        @(negedge clk);
        addr = 8'd100; req = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (G - 1) @(negedge clk);
        rst_pin_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        chk(perm_t == 0 && perm_b == 0, "R9 pin low at close", perm_t, 0);
        rst_pin_n = 1'b1; ce_n = 1'b1; req = 1'b0;
        repeat (2) @(negedge clk);
        chk(rdy_t == 1 && abort_t == 0, "R7 two-sample pulse ignored", rdy_t, 1);

        finish_run();
    end

endmodule